// File: doc/BRIEF.md
# Parallel Display Bus Transfer Engine

This block moves data between a register-mapped host port and an external display controller over an 8-bit or 16-bit parallel bus. The host writes bytes, halfwords or whole words into an eight-entry transmit queue. The engine cuts every queued entry into bus beats, lowest byte or halfword first, and drives a write strobe for each beat. Strobe timing is counted in ticks of a divided clock. A programmed cycle count ends each burst. In the read direction the engine pulses a read strobe, samples the bus and packs the samples into words that the host reads back.

Chip select and command/data select follow host-controlled bits directly. A burst starts when the block is enabled and the host asserts both chip select and the write-enable control. A status bit reports when every queued write has left the bus. A request output invites DMA to refill the queue. An identification register returns a fixed read sequence, which software uses to check that the block is present.

Top module: `pdb_engine`

Register map (word index on `reg_sel`): 0 identification, 1 bus configuration, 2 control/status, 3 pick configuration, 4 data. Bus configuration: bits 17:0 hold the cycle count minus one, bit 18 is command(0)/data(1), bit 19 enables DMA, bits 23:20 hold the active ticks minus one, bits 29:24 hold the recovery ticks minus one, and bit 30 is chip select (active low). Control/status: bit 0 enable, bit 1 soft reset, bit 3 done (read-only), bit 4 write-enable control (0 = active), bit 5 direction (1 = read). Pick configuration: bits 4:0 hold the pick width minus one (15 or more selects 16 bits, otherwise 8 bits), bits 9:5 hold the pick count minus one, and bits 12:10 hold the clock divider minus one.

## Requirements
- R1: After reset, bus_cs_n, bus_wr_n and bus_rd_n are 1, dma_req is 0 and the done bit (control/status bit 3) reads 1.
- R2: After any write to the identification register, successive reads return 0x55555555, 0xAAAAAAAA, the component code, and then {major[15:0], minor[15:0]}. Further reads keep returning that last word.
- R3: With divider D (1 to 8) and active field A, every strobe stays low for exactly (A+1)*D clocks. Each bus cycle spends one tick high before its strobe falls, so while data is ready successive strobe falls are (A+R'+3)*D clocks apart, where R' is the recovery field.
- R4: A recovery field value below 2 is treated as 2, so recovery never lasts less than 3 ticks.
- R5: In 8-bit mode a 32-bit entry leaves as 4 beats on bus_dout[7:0], with bus_dout[15:8] = 0. In 16-bit mode it leaves as 2 beats. In both modes the least significant byte or halfword goes first.
- R6: A data write of size 1 (reg_size=1) supplies 2 bytes and a write of size 0 supplies 1 byte. The pick logic sends only those bytes; in 16-bit mode a single byte leaves as one beat with its upper byte zero.
- R7: A burst starts on the rising edge of (enable AND chip select active AND write-enable control active) and performs exactly cycle field + 1 bus cycles.
- R8: The done bit reads 0 while a burst runs or while the queue holds data. It reads 1 once the burst has counted out and the queue is empty.
- R9: The queue holds 8 entries. A data write stalls (reg_ready=0) while the queue is full. dma_req = DMA enable AND queue not full.
- R10: bus_cs_n follows bus configuration bit 30 and bus_dc follows bit 18.
- R11: In the read direction bus_rd_n pulses with the write timing and bus_wr_n stays high. Each sample is taken at the end of its strobe and packed lowest lane first into 32-bit words. A final partial word has zero upper bytes.
- R12: With the enable bit clear no strobe occurs. Soft reset empties the queue, so done reads 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 3 | Register word index |
| reg_wr | input | 1 | Register write request |
| reg_rd | input | 1 | Register read request |
| reg_size | input | 2 | Data write size: 0 byte, 1 halfword, 2 word |
| reg_wdata | input | 32 | Write data |
| reg_ready | output | 1 | Access accepted this cycle |
| reg_rdata | output | 32 | Read data, valid the cycle after acceptance |
| dma_req | output | 1 | Queue has room and DMA mode is on |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_dc | output | 1 | Command (0) / data (1) select |
| bus_dout | output | 16 | Outgoing bus beat |
| bus_din | input | 16 | Incoming bus data |

## Verification
A host push into a full queue and the sequencer's pop that frees a slot can land in the same cycle. The bench fills all eight entries and raises a ninth write, which must see reg_ready low, and then starts a burst so that the queued write is absorbed by the first pop. The bench then counts all eighteen beats and compares their values, so no entry is lost or repeated at that boundary. The done bit is read both while the burst runs and after it ends, which separates "counter expired" from "queue drained". A timing sweep over width, divider, active and recovery values covers every clamp case.

// File: rtl/pdb_pkg.sv
package pdb_pkg;
    localparam int WORD_W = 32;
    localparam int BUS_W  = 16;
    localparam int CYC_W  = 18;
    localparam int DIV_W  = 3;

    localparam logic [2:0] SEL_ID   = 3'd0;
    localparam logic [2:0] SEL_BUS  = 3'd1;
    localparam logic [2:0] SEL_CTL  = 3'd2;
    localparam logic [2:0] SEL_PICK = 3'd3;
    localparam logic [2:0] SEL_DATA = 3'd4;

    localparam int A_DC   = 18;
    localparam int A_DMA  = 19;
    localparam int A_CS   = 30;
    localparam int C_EN   = 0;
    localparam int C_SRST = 1;
    localparam int C_DONE = 3;
    localparam int C_WE   = 4;
    localparam int C_DIR  = 5;

    localparam logic [31:0] SYNC_A = 32'h5555_5555;
    localparam logic [31:0] SYNC_B = 32'hAAAA_AAAA;

    localparam logic [31:0] BUS_RST  = 32'h4000_0000;
    localparam logic [31:0] CTL_RST  = 32'h0000_0010;
    localparam logic [31:0] PICK_RST = 32'h0000_0067;

    typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_ACT, ST_TAIL} seq_state_e;

    typedef struct packed {
        logic [2:0]        nbytes;
        logic [WORD_W-1:0] data;
    } tx_entry_t;

    function automatic tx_entry_t fn_make_entry(input logic [1:0] size,
                                                input logic [WORD_W-1:0] wd);
        tx_entry_t e;
        case (size)
            2'd0:    begin e.nbytes = 3'd1; e.data = {24'h0, wd[7:0]};  end
            2'd1:    begin e.nbytes = 3'd2; e.data = {16'h0, wd[15:0]}; end
            default: begin e.nbytes = 3'd4; e.data = wd;                end
        endcase
        return e;
    endfunction

    function automatic logic [5:0] fn_rest_guard(input logic [5:0] r);
        return (r < 6'd2) ? 6'd2 : r;
    endfunction
endpackage

// File: rtl/pdb_tick.sv
module pdb_tick import pdb_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div_m1,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div_m1);

    always_ff @(posedge clk) begin
        if (rst || !run)        cnt <= '0;
        else if (cnt == div_m1) cnt <= '0;
        else                    cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pdb_txq.sv
module pdb_txq import pdb_pkg::*; #(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        push,
    input  tx_entry_t   push_entry,
    input  logic        pop,
    output tx_entry_t   head,
    output logic        full,
    output logic        empty,
    output logic [$clog2(DEPTH):0] count
);
    localparam int AW = $clog2(DEPTH);

    tx_entry_t       mem [DEPTH];
    logic [AW-1:0]   wp, rp;
    logic            do_push, do_pop;

    assign full    = (count == DEPTH[AW:0]);
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) begin
                mem[wp] <= push_entry;
                wp      <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            end
            if (do_pop)
                rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/pdb_seq.sv
module pdb_seq import pdb_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             rd_mode,
    input  logic             wide,
    input  logic [3:0]       act_m1,
    input  logic [5:0]       rest_m1,
    input  logic [CYC_W-1:0] cycles_m1,
    input  logic             tick,
    input  logic             q_empty,
    input  tx_entry_t        q_head,
    output logic             q_pop,
    input  logic [BUS_W-1:0] bus_din,
    input  logic             rx_take,
    output logic             busy,
    output logic             have_entry,
    output logic             wr_n,
    output logic             rd_n,
    output logic [BUS_W-1:0] dout,
    output logic [WORD_W-1:0] rx_word,
    output logic             rx_valid
);
    seq_state_e       st;
    logic [CYC_W:0]   remain;
    logic [5:0]       tcnt;
    logic             dir_rd;
    tx_entry_t        cur;
    logic [2:0]       off;
    logic [WORD_W-1:0] acc;
    logic [2:0]       acc_off;

    logic [5:0]        rest_lim;
    logic [2:0]        bpp;
    logic              can_go;
    logic [WORD_W-1:0] shifted;
    logic [BUS_W-1:0]  pick_in;
    logic [WORD_W-1:0] acc_nx;
    logic [2:0]        acc_off_nx;
    logic [2:0]        off_nx;
    logic              last_cyc;

    assign rest_lim   = fn_rest_guard(rest_m1);
    assign bpp        = wide ? 3'd2 : 3'd1;
    assign can_go     = dir_rd ? !rx_valid : have_entry;
    assign shifted    = cur.data >> {off, 3'b000};
    assign pick_in    = wide ? bus_din : {8'h00, bus_din[7:0]};
    assign acc_nx     = acc | ({16'h0000, pick_in} << {acc_off, 3'b000});
    assign acc_off_nx = acc_off + bpp;
    assign off_nx     = off + bpp;
    assign last_cyc   = (remain == {{CYC_W{1'b0}}, 1'b1});

    assign busy  = (st != ST_IDLE);
    assign q_pop = busy && !have_entry && !q_empty;
    assign wr_n  = !(st == ST_ACT && !dir_rd);
    assign rd_n  = !(st == ST_ACT && dir_rd);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            remain     <= '0;
            tcnt       <= '0;
            dir_rd     <= 1'b0;
            cur        <= '0;
            have_entry <= 1'b0;
            off        <= '0;
            acc        <= '0;
            acc_off    <= '0;
            dout       <= '0;
            rx_word    <= '0;
            rx_valid   <= 1'b0;
        end else begin
            if (q_pop) begin
                cur        <= q_head;
                have_entry <= 1'b1;
                off        <= '0;
            end
            if (rx_take)
                rx_valid <= 1'b0;
            case (st)
                ST_IDLE: if (start) begin
                    st      <= ST_LEAD;
                    remain  <= {1'b0, cycles_m1} + 1'b1;
                    tcnt    <= '0;
                    dir_rd  <= rd_mode;
                    acc     <= '0;
                    acc_off <= '0;
                end
                ST_LEAD: if (tick && can_go) begin
                    st   <= ST_ACT;
                    tcnt <= '0;
                    if (!dir_rd) begin
                        dout <= wide ? shifted[15:0] : {8'h00, shifted[7:0]};
                        off  <= off_nx;
                        if (off_nx >= cur.nbytes)
                            have_entry <= 1'b0;
                    end
                end
                ST_ACT: if (tick) begin
                    if (tcnt == {2'b00, act_m1}) begin
                        st   <= ST_TAIL;
                        tcnt <= '0;
                        if (dir_rd) begin
                            if (acc_off_nx >= 3'd4 || last_cyc) begin
                                rx_word  <= acc_nx;
                                rx_valid <= 1'b1;
                                acc      <= '0;
                                acc_off  <= '0;
                            end else begin
                                acc     <= acc_nx;
                                acc_off <= acc_off_nx;
                            end
                        end
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                ST_TAIL: if (tick) begin
                    if (tcnt == rest_lim) begin
                        tcnt   <= '0;
                        remain <= remain - 1'b1;
                        st     <= last_cyc ? ST_IDLE : ST_LEAD;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pdb_engine.sv
module pdb_engine import pdb_pkg::*; #(
    parameter int          FIFO_DEPTH = 8,
    parameter logic [31:0] COMP_CODE  = 32'h0000_0C5D,
    parameter logic [15:0] VER_MAJOR  = 16'd2,
    parameter logic [15:0] VER_MINOR  = 16'd1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_size,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic              reg_ready,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              dma_req,
    output logic              bus_cs_n,
    output logic              bus_wr_n,
    output logic              bus_rd_n,
    output logic              bus_dc,
    output logic [BUS_W-1:0]  bus_dout,
    input  logic [BUS_W-1:0]  bus_din
);
    localparam int CW = $clog2(FIFO_DEPTH) + 1;

    logic [WORD_W-1:0] ctrl_a, ctrl_b, ctrl_c;
    logic [1:0]        id_idx;
    logic              go, go_q, start;
    logic              core_rst;
    logic              wide;
    logic [DIV_W-1:0]  div_m1;
    logic              tick, busy, have_entry;
    logic              q_full, q_empty, q_pop, q_push;
    logic [CW-1:0]     q_count;
    tx_entry_t         q_head;
    logic [WORD_W-1:0] rx_word;
    logic              rx_valid, rx_take;
    logic              done_flag;
    logic              data_wr, data_rd;
    logic [WORD_W-1:0] id_word, rd_mux;

    assign core_rst  = rst || ctrl_b[C_SRST];
    assign go        = ctrl_b[C_EN] && !ctrl_a[A_CS] && !ctrl_b[C_WE];
    assign start     = go && !go_q;
    assign wide      = (ctrl_c[4:0] >= 5'd15);
    assign div_m1    = ctrl_c[12:10];
    assign done_flag = !busy && q_empty && !have_entry;

    assign data_wr   = reg_wr && (reg_sel == SEL_DATA);
    assign data_rd   = reg_rd && (reg_sel == SEL_DATA);
    assign reg_ready = !(data_wr && q_full) && !(data_rd && !rx_valid);
    assign q_push    = data_wr && !q_full;
    assign rx_take   = data_rd && rx_valid;

    assign dma_req   = ctrl_a[A_DMA] && (q_count < CW'(FIFO_DEPTH));
    assign bus_cs_n  = ctrl_a[A_CS];
    assign bus_dc    = ctrl_a[A_DC];

    always_comb begin
        case (id_idx)
            2'd0:    id_word = SYNC_A;
            2'd1:    id_word = SYNC_B;
            2'd2:    id_word = COMP_CODE;
            default: id_word = {VER_MAJOR, VER_MINOR};
        endcase
        case (reg_sel)
            SEL_ID:   rd_mux = id_word;
            SEL_BUS:  rd_mux = ctrl_a;
            SEL_CTL:  rd_mux = {ctrl_b[31:4], done_flag, ctrl_b[2:0]};
            SEL_PICK: rd_mux = ctrl_c;
            SEL_DATA: rd_mux = rx_word;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_a    <= BUS_RST;
            ctrl_b    <= CTL_RST;
            ctrl_c    <= PICK_RST;
            id_idx    <= '0;
            go_q      <= 1'b0;
            reg_rdata <= '0;
        end else begin
            go_q <= go;
            if (reg_wr) begin
                case (reg_sel)
                    SEL_ID:   id_idx <= '0;
                    SEL_BUS:  ctrl_a <= reg_wdata;
                    SEL_CTL:  ctrl_b <= reg_wdata & ~(32'h1 << C_DONE);
                    SEL_PICK: ctrl_c <= reg_wdata;
                    default:  ;
                endcase
            end else if (reg_rd && reg_sel == SEL_ID && id_idx != 2'd3) begin
                id_idx <= id_idx + 1'b1;
            end
            if (reg_rd && reg_ready)
                reg_rdata <= rd_mux;
        end
    end

    pdb_tick u_tick (
        .clk    (clk),
        .rst    (core_rst),
        .run    (busy),
        .div_m1 (div_m1),
        .tick   (tick)
    );

    pdb_txq #(.DEPTH(FIFO_DEPTH)) u_txq (
        .clk        (clk),
        .rst        (core_rst),
        .push       (q_push),
        .push_entry (fn_make_entry(reg_size, reg_wdata)),
        .pop        (q_pop),
        .head       (q_head),
        .full       (q_full),
        .empty      (q_empty),
        .count      (q_count)
    );

    pdb_seq u_seq (
        .clk        (clk),
        .rst        (core_rst),
        .start      (start),
        .rd_mode    (ctrl_b[C_DIR]),
        .wide       (wide),
        .act_m1     (ctrl_a[23:20]),
        .rest_m1    (ctrl_a[29:24]),
        .cycles_m1  (ctrl_a[CYC_W-1:0]),
        .tick       (tick),
        .q_empty    (q_empty),
        .q_head     (q_head),
        .q_pop      (q_pop),
        .bus_din    (bus_din),
        .rx_take    (rx_take),
        .busy       (busy),
        .have_entry (have_entry),
        .wr_n       (bus_wr_n),
        .rd_n       (bus_rd_n),
        .dout       (bus_dout),
        .rx_word    (rx_word),
        .rx_valid   (rx_valid)
    );
endmodule

// File: rtl/pdb_chk.sv
module pdb_chk import pdb_pkg::*; #(
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr_n,
    input logic              bus_rd_n,
    input logic              bus_cs_n,
    input logic [2:0]        reg_sel,
    input logic              reg_wr,
    input logic [WORD_W-1:0] reg_wdata,
    input logic [3:0]        act_m1,
    input logic [DIV_W-1:0]  div_m1,
    input logic              done_flag,
    input logic [CW-1:0]     q_count
);
    logic        wr_q;
    logic [15:0] low_cnt;
    logic [15:0] low_exp;

    assign low_exp = 16'((act_m1 + 1) * (div_m1 + 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q    <= 1'b1;
            low_cnt <= '0;
        end else begin
            wr_q    <= bus_wr_n;
            low_cnt <= bus_wr_n ? 16'd0 : low_cnt + 16'd1;
        end
    end

    // R3: strobe low time equals active ticks times divider
    assert_strobe_width_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_n && !wr_q) |-> (low_cnt == low_exp));

    // R11: read and write strobes never overlap
    assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (rst)
        !(!bus_wr_n && !bus_rd_n));

    // R9: queue occupancy bounded by depth
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        q_count <= CW'(DEPTH));

    // R8: done is never reported while a write beat is on the bus
    assert_done_clear_R8: assert property (@(posedge clk) disable iff (rst)
        !bus_wr_n |-> !done_flag);

    // R10: chip select follows the written control bit
    assert_cs_follow_R10: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel == SEL_BUS) |=> (bus_cs_n == $past(reg_wdata[30])));
endmodule

bind pdb_engine pdb_chk #(.DEPTH(FIFO_DEPTH), .CW(CW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr_n  (bus_wr_n),
    .bus_rd_n  (bus_rd_n),
    .bus_cs_n  (bus_cs_n),
    .reg_sel   (reg_sel),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .act_m1    (ctrl_a[23:20]),
    .div_m1    (div_m1),
    .done_flag (done_flag),
    .q_count   (q_count)
);

// File: tb/tb_pdb_engine.sv
module tb_pdb_engine;
    import pdb_pkg::*;

    logic        clk = 0;
    logic        rst = 1;
    logic [2:0]  reg_sel = 0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [1:0]  reg_size = 2;
    logic [31:0] reg_wdata = 0;
    logic        reg_ready;
    logic [31:0] reg_rdata;
    logic        dma_req, bus_cs_n, bus_wr_n, bus_rd_n, bus_dc;
    logic [15:0] bus_dout;
    logic [15:0] bus_din = 0;

    int total = 0, bad = 0;
    int cyc = 0;
    int nb = 0, rn = 0, lowc = 0;
    logic [15:0] bv [0:63];
    int ft [0:63];
    int ll [0:63];
    logic [15:0] expb [0:63];
    logic wr_p = 1, rd_p = 1;
    bit finished = 0;

    always #4 clk = ~clk;

    pdb_engine dut (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_size(reg_size), .reg_wdata(reg_wdata), .reg_ready(reg_ready),
        .reg_rdata(reg_rdata), .dma_req(dma_req), .bus_cs_n(bus_cs_n),
        .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n), .bus_dc(bus_dc),
        .bus_dout(bus_dout), .bus_din(bus_din)
    );

    function automatic logic [15:0] pat(input int k);
        return 16'h0A0B + 16'(k) * 16'h1357;
    endfunction

    always @(negedge clk) begin
        cyc++;
        if (!bus_wr_n && wr_p) begin
            if (nb < 64) begin bv[nb] = bus_dout; ft[nb] = cyc; end
            lowc = 1;
        end else if (!bus_wr_n) begin
            lowc++;
        end
        if (bus_wr_n && !wr_p) begin
            if (nb < 64) ll[nb] = lowc;
            nb++;
        end
        if (!bus_rd_n && rd_p) bus_din = pat(rn);
        if (bus_rd_n && !rd_p) rn++;
        wr_p = bus_wr_n;
        rd_p = bus_rd_n;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [2:0] s, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        reg_sel = s; reg_size = sz; reg_wdata = d; reg_wr = 1;
        #1;
        while (!reg_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rreg(input logic [2:0] s, output logic [31:0] v);
        @(negedge clk);
        reg_sel = s; reg_rd = 1;
        #1;
        while (!reg_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        reg_rd = 0;
        v = reg_rdata;
    endtask

    function automatic logic [31:0] mk_a(input bit cs, input bit dma, input int act,
                                         input int rest, input bit dc, input int cycm1);
        return {1'b0, cs, 6'(rest), 4'(act), dma, dc, 18'(cycm1)};
    endfunction

    function automatic logic [31:0] mk_c(input int dv, input bit wide);
        logic [4:0] pw, pc;
        pw = wide ? 5'd15 : 5'd7;
        pc = wide ? 5'd1 : 5'd3;
        return {19'd0, 3'(dv - 1), pc, pw};
    endfunction

    task automatic wait_beats(input int n);
        for (int t = 0; t < 8000 && nb < n; t++) @(negedge clk);
    endtask

    task automatic run_wr(input bit wide, input int dv, input int a, input int r, input int it);
        logic [31:0] w0, v;
        int np, gap, rl;
        w0 = 32'hA1B2C3D4 ^ (it * 32'h01010101);
        if (wide) begin
            expb[0] = w0[15:0]; expb[1] = w0[31:16]; expb[2] = 16'h5E6F; expb[3] = 16'h0097;
            np = 4;
        end else begin
            expb[0] = {8'h0, w0[7:0]};   expb[1] = {8'h0, w0[15:8]};
            expb[2] = {8'h0, w0[23:16]}; expb[3] = {8'h0, w0[31:24]};
            expb[4] = 16'h006F; expb[5] = 16'h005E; expb[6] = 16'h0097;
            np = 7;
        end
        nb = 0;
        wreg(SEL_CTL, 2, 32'h11);
        wreg(SEL_PICK, 2, mk_c(dv, wide));
        wreg(SEL_BUS, 2, mk_a(1, 0, a, r, 1, np - 1));
        wreg(SEL_DATA, 2, w0);
        wreg(SEL_DATA, 1, 32'hFFFF5E6F);
        wreg(SEL_DATA, 0, 32'hFFFFFF97);
        rreg(SEL_CTL, v);
        chk(v[3] == 1'b0, "R8 queued data clears done", v[3], 0);
        wreg(SEL_BUS, 2, mk_a(0, 0, a, r, 1, np - 1));
        wreg(SEL_CTL, 2, 32'h01);
        rreg(SEL_CTL, v);
        chk(v[3] == 1'b0, "R8 done low during burst", v[3], 0);
        wait_beats(np);
        repeat (60) @(negedge clk);
        chk(nb == np, "R7 beat count", nb, np);
        for (int i = 0; i < np && i < nb; i++) begin
            chk(bv[i] == expb[i], wide ? "R5 R6 16-bit beat" : "R5 R6 8-bit beat", bv[i], expb[i]);
            chk(ll[i] == (a + 1) * dv, "R3 strobe low width", ll[i], (a + 1) * dv);
        end
        rl = (r < 2) ? 2 : r;
        for (int i = 0; i + 1 < np && i + 1 < nb; i++) begin
            gap = ft[i + 1] - ft[i];
            chk(gap == (a + rl + 3) * dv, (r < 2) ? "R4 guarded cycle" : "R3 cycle period",
                gap, (a + rl + 3) * dv);
        end
        rreg(SEL_CTL, v);
        chk(v[3] == 1'b1, "R8 done after burst", v[3], 1);
        wreg(SEL_CTL, 2, 32'h11);
        wreg(SEL_BUS, 2, mk_a(1, 0, a, r, 1, np - 1));
    endtask

    initial begin
        logic [31:0] v, e;
        int it;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(bus_cs_n === 1'b1, "R1 cs_n", bus_cs_n, 1);
        chk(bus_wr_n === 1'b1 && bus_rd_n === 1'b1, "R1 strobes", {bus_wr_n, bus_rd_n}, 3);
        chk(dma_req === 1'b0, "R1 dma_req", dma_req, 0);
        rreg(SEL_CTL, v);
        chk(v[3] == 1'b1, "R1 done at reset", v[3], 1);

        // R2 identification sequence
        for (int pass = 0; pass < 2; pass++) begin
            wreg(SEL_ID, 2, 0);
            for (int k = 0; k < 5; k++) begin
                rreg(SEL_ID, v);
                e = (k == 0) ? 32'h55555555 : (k == 1) ? 32'hAAAAAAAA :
                    (k == 2) ? 32'h00000C5D : 32'h00020001;
                chk(v == e, "R2 id word", v, e);
            end
        end

        // R10 direct control pins
        wreg(SEL_BUS, 2, mk_a(0, 0, 0, 0, 0, 0));
        chk(bus_cs_n == 1'b0 && bus_dc == 1'b0, "R10 cs/dc low", {bus_cs_n, bus_dc}, 0);
        wreg(SEL_BUS, 2, mk_a(1, 0, 0, 0, 1, 0));
        chk(bus_cs_n == 1'b1 && bus_dc == 1'b1, "R10 cs/dc high", {bus_cs_n, bus_dc}, 3);

        // R3 R4 R5 R6 R7 R8 timing and packing sweep
        it = 0;
        for (int w = 0; w < 2; w++)
            for (int dv = 1; dv <= 3; dv++)
                for (int a = 0; a <= 2; a += 2)
                    for (int r = 0; r <= 3; r++) begin
                        if (r == 2) continue;
                        run_wr(w[0], dv, a, r, it);
                        it++;
                    end

        // R9 full queue, stall and DMA request
        nb = 0;
        wreg(SEL_PICK, 2, mk_c(1, 1));
        wreg(SEL_BUS, 2, mk_a(1, 1, 0, 0, 1, 17));
        chk(dma_req == 1'b1, "R9 dma_req with room", dma_req, 1);
        for (int k = 0; k < 8; k++) wreg(SEL_DATA, 2, 32'h01020304 + k * 32'h11111111);
        chk(dma_req == 1'b0, "R9 dma_req when full", dma_req, 0);
        @(negedge clk);
        reg_sel = SEL_DATA; reg_size = 2; reg_wdata = 32'h9ABCDEF0; reg_wr = 1;
        #1;
        chk(reg_ready == 1'b0, "R9 stall when full", reg_ready, 0);
        repeat (3) @(negedge clk);
        chk(reg_ready == 1'b0, "R9 stall holds", reg_ready, 0);
        reg_wr = 0;
        wreg(SEL_BUS, 2, mk_a(0, 1, 0, 0, 1, 17));
        wreg(SEL_CTL, 2, 32'h01);
        wreg(SEL_DATA, 2, 32'h9ABCDEF0);
        wait_beats(18);
        repeat (30) @(negedge clk);
        chk(nb == 18, "R9 beats after refill", nb, 18);
        for (int k = 0; k < 9 && 2 * k + 1 < nb; k++) begin
            e = (k == 8) ? 32'h9ABCDEF0 : 32'h01020304 + k * 32'h11111111;
            chk(bv[2 * k] == e[15:0] && bv[2 * k + 1] == e[31:16], "R9 R5 word order",
                {bv[2 * k + 1], bv[2 * k]}, e);
        end
        chk(dma_req == 1'b1, "R9 dma_req after drain", dma_req, 1);
        rreg(SEL_CTL, v);
        chk(v[3] == 1'b1, "R8 done after drain", v[3], 1);
        wreg(SEL_CTL, 2, 32'h11);

        // R11 read direction, 8-bit then 16-bit
        nb = 0; rn = 0;
        wreg(SEL_PICK, 2, mk_c(2, 0));
        wreg(SEL_BUS, 2, mk_a(0, 0, 1, 0, 1, 5));
        wreg(SEL_CTL, 2, 32'h31);
        wreg(SEL_CTL, 2, 32'h21);
        rreg(SEL_DATA, v);
        e = {pat(3)[7:0], pat(2)[7:0], pat(1)[7:0], pat(0)[7:0]};
        chk(v == e, "R11 8-bit read word", v, e);
        rreg(SEL_DATA, v);
        e = {16'h0, pat(5)[7:0], pat(4)[7:0]};
        chk(v == e, "R11 8-bit partial word", v, e);
        repeat (30) @(negedge clk);
        chk(rn == 6 && nb == 0, "R11 read strobes only", {rn[15:0], nb[15:0]}, {16'd6, 16'd0});
        wreg(SEL_CTL, 2, 32'h31);
        rn = 0;
        wreg(SEL_PICK, 2, mk_c(1, 1));
        wreg(SEL_BUS, 2, mk_a(0, 0, 0, 0, 1, 2));
        wreg(SEL_CTL, 2, 32'h21);
        rreg(SEL_DATA, v);
        e = {pat(1), pat(0)};
        chk(v == e, "R11 16-bit read word", v, e);
        rreg(SEL_DATA, v);
        e = {16'h0, pat(2)};
        chk(v == e, "R11 16-bit partial word", v, e);
        wreg(SEL_CTL, 2, 32'h10);
        wreg(SEL_BUS, 2, mk_a(1, 0, 0, 0, 1, 0));

        // R12 enable gate and soft reset
        nb = 0;
        wreg(SEL_DATA, 2, 32'h12345678);
        wreg(SEL_BUS, 2, mk_a(0, 0, 0, 0, 1, 1));
        wreg(SEL_CTL, 2, 32'h00);
        repeat (100) @(negedge clk);
        chk(nb == 0, "R12 no strobe when disabled", nb, 0);
        rreg(SEL_CTL, v);
        chk(v[3] == 1'b0, "R12 queue holds data", v[3], 0);
        wreg(SEL_CTL, 2, 32'h12);
        wreg(SEL_CTL, 2, 32'h10);
        rreg(SEL_CTL, v);
        chk(v[3] == 1'b1, "R12 soft reset empties queue", v[3], 1);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        wait (cyc > 150000);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule